// File: doc/BRIEF.md
# Flat Page-Table Address Translator

This block turns 32-bit virtual addresses from a graphics-style client into physical addresses for a memory port. It uses one flat table of 32-bit entries in memory, indexed by the virtual page number. Pages are 4 KB. An entry can also mark a 1 MB superpage. The most recent translations are kept in a small fully associative cache of table entries (TLB). On a TLB miss the client stalls while the block reads the entry over a simple request/acknowledge port.

Each completed access is checked for three faults: an invalid entry, a write to a read-only page, and a table address that overflows the physical space. Every fault type has its own abort enable and interrupt enable. An optional scratch page can absorb faulting accesses instead of aborting them. Fault causes and the last faulting address stay latched until software clears them. A self-clearing command empties the TLB, and software polls a busy flag to see when it has finished.

The client raises `req_valid` and holds the address and write flag until `resp_valid` pulses for one cycle. It then lowers or changes the request in the cycle after that pulse. Register reads are combinational on `reg_addr`. Register writes take effect at the clock edge where `reg_we` is high.

Register map (`reg_addr`):
- 0 is control. Bit 0 enables the invalid-entry check. Bits 1 and 2 are the invalid abort and interrupt enables. Bits 3 and 4 are the write-violation abort and interrupt enables. Bits 5 and 6 are the overflow abort and interrupt enables. Bit 8 is the clear command (write only). Bit 9 is the clearing-busy flag (read only).
- 1 is the table base, as a physical page number in bits 19:0.
- 2 is the scratch page number in bits 19:0, with its enable in bit 31.
- 3 is the fault cause. Bit 0 is invalid, bit 1 is write violation, bit 2 is overflow. Writing 1 to a bit clears it.
- 4 is the last faulting virtual address (read only).

Top module: `pt_mmu`

## Requirements
- R1: For a valid 4 KB entry, the response address is the entry's bits 19:0 followed by the request's bits 11:0, and `resp_abort` is 0.
- R2: On a miss, `pte_rd_addr` is (table base << 12) + VPN*4. `pte_rd_req` and `pte_rd_addr` stay steady until `pte_rd_ack`.
- R3: A later access to a cached page completes without a table read. The TLB holds 8 entries that are refilled in round-robin order, so the ninth distinct page evicts the first.
- R4: An entry with bit 31 set is a superpage. The response address is entry bits 19:8, then request bits 19:0. Any page in the same 1 MB region then hits without a table read.
- R5: An entry with bit 28 clear is invalid. When control bit 0 is set, an invalid entry latches cause bit 0 and aborts if control bit 1 is set. Invalid entries are never cached. With the abort disabled, the access completes using the entry's page number.
- R6: A write to an entry with bit 29 clear latches cause bit 1 and aborts if control bit 3 is set. A read of the same page completes without a fault.
- R7: If the entry address overflows 32 bits, no table read is issued and cause bit 2 is latched. The access aborts if control bit 5 is set. Otherwise it completes on physical page 0.
- R8: With the scratch enable set, a faulting access completes at the scratch page plus the request's offset, with no abort, and the cause is still latched.
- R9: Causes are sticky until written with 1. Register 4 holds the VA of the last fault. `irq` is the OR of each latched cause with its interrupt enable (control bits 2, 4, 6).
- R10: Writing control bit 8 makes bit 9 read 1 at once. Bit 9 drops by itself, and afterwards every earlier cached page misses. No table read starts while the flag is set.
- R11: `resp_valid` is a one-cycle pulse for each accepted request. `resp_abort` is only ever 1 together with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Client request present |
| req_addr | input | 32 | Client virtual address |
| req_write | input | 1 | Request is a write |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_addr | output | 32 | Translated physical address |
| resp_abort | output | 1 | Access aborted by a fault |
| pte_rd_req | output | 1 | Table-entry read request |
| pte_rd_addr | output | 32 | Physical address of the entry |
| pte_rd_ack | input | 1 | Entry data valid |
| pte_rd_data | input | 32 | Fetched table entry |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| irq | output | 1 | Fault interrupt |

## Verification
The bench targets round-robin eviction on the ninth distinct page. A replacement pointer that stalled or skipped would leave the first page cached, or evict the wrong one. It also checks that a neighbouring page in a superpage hits without a table read and gets the request's bits 19:12 spliced in. A design that compared full page numbers would fetch again, and a design that dropped the splice would return the wrong address. Invalid entries must be fetched again on every access; caching them would hide the second fault. The bench also checks that an overflowing entry address skips the read port, and that the busy flag is visible on the very cycle after the clear command and then empties the TLB. Random traffic with mixed enables then compares every response and the sticky cause register against a bench model.

// File: rtl/pt_mmu_pkg.sv
package pt_mmu_pkg;
   localparam int PTE_W      = 32;
   localparam int PTE_SP_BIT = 31;
   localparam int PTE_WR_BIT = 29;
   localparam int PTE_V_BIT  = 28;

   localparam int FLT_N  = 3;
   localparam int FI_INV = 0;
   localparam int FI_WV  = 1;
   localparam int FI_CAP = 2;

   localparam int CTL_W       = 7;
   localparam int CB_INV_CHK  = 0;
   localparam int CB_INV_AB   = 1;
   localparam int CB_INV_IE   = 2;
   localparam int CB_WV_AB    = 3;
   localparam int CB_WV_IE    = 4;
   localparam int CB_CAP_AB   = 5;
   localparam int CB_CAP_IE   = 6;
   localparam int CB_CLR      = 8;
   localparam int CB_BUSY     = 9;

   localparam logic [2:0] RA_CTL   = 3'd0;
   localparam logic [2:0] RA_BASE  = 3'd1;
   localparam logic [2:0] RA_SCR   = 3'd2;
   localparam logic [2:0] RA_CAUSE = 3'd3;
   localparam logic [2:0] RA_FVA   = 3'd4;

   typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_DONE} walk_st_e;
endpackage

// File: rtl/pt_mmu_regs.sv
module pt_mmu_regs
   import pt_mmu_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int VPN_W  = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] reg_rdata,
   input  logic              clr_ok,
   input  logic [FLT_N-1:0]  flt_set,
   input  logic [ADDR_W-1:0] flt_va,
   output logic              inv_chk,
   output logic [FLT_N-1:0]  abt_en,
   output logic [VPN_W-1:0]  tbase,
   output logic [VPN_W-1:0]  scr_ppn,
   output logic              scr_en,
   output logic              clr_busy,
   output logic              clr_fire,
   output logic              irq
);
   logic [CTL_W-1:0]  ctl;
   logic [FLT_N-1:0]  cause, irq_en, w1c;
   logic [ADDR_W-1:0] fva;
   logic              wr_ctl;

   assign wr_ctl   = reg_we && (reg_addr == RA_CTL);
   assign w1c      = (reg_we && reg_addr == RA_CAUSE) ? reg_wdata[FLT_N-1:0] : '0;
   assign clr_fire = clr_busy && clr_ok;
   assign inv_chk  = ctl[CB_INV_CHK];
   assign abt_en   = {ctl[CB_CAP_AB], ctl[CB_WV_AB], ctl[CB_INV_AB]};
   assign irq_en   = {ctl[CB_CAP_IE], ctl[CB_WV_IE], ctl[CB_INV_IE]};
   assign irq      = |(cause & irq_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl      <= '0;
         tbase    <= '0;
         scr_ppn  <= '0;
         scr_en   <= 1'b0;
         clr_busy <= 1'b0;
         cause    <= '0;
         fva      <= '0;
      end else begin
         if (wr_ctl) ctl <= reg_wdata[CTL_W-1:0];
         if (reg_we && reg_addr == RA_BASE) tbase <= reg_wdata[VPN_W-1:0];
         if (reg_we && reg_addr == RA_SCR) begin
            scr_ppn <= reg_wdata[VPN_W-1:0];
            scr_en  <= reg_wdata[ADDR_W-1];
         end
         if (wr_ctl && reg_wdata[CB_CLR]) clr_busy <= 1'b1;
         else if (clr_fire)               clr_busy <= 1'b0;
         cause <= (cause & ~w1c) | flt_set;
         if (|flt_set) fva <= flt_va;
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         RA_CTL: begin
            reg_rdata[CTL_W-1:0] = ctl;
            reg_rdata[CB_BUSY]   = clr_busy;
         end
         RA_BASE:  reg_rdata[VPN_W-1:0] = tbase;
         RA_SCR: begin
            reg_rdata[VPN_W-1:0]  = scr_ppn;
            reg_rdata[ADDR_W-1]   = scr_en;
         end
         RA_CAUSE: reg_rdata[FLT_N-1:0] = cause;
         RA_FVA:   reg_rdata = fva;
         default:  reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/pt_mmu_tlb.sv
module pt_mmu_tlb #(
   parameter int VPN_W   = 20,
   parameter int ENTRIES = 8,
   parameter int SP_BITS = 8,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VPN_W-1:0] lk_vpn,
   output logic             hit,
   output logic [VPN_W-1:0] hit_ppn,
   output logic             hit_wr,
   input  logic             fill_en,
   input  logic [VPN_W-1:0] fill_ppn,
   input  logic             fill_sp,
   input  logic             fill_wr,
   input  logic             clr
);
   logic [ENTRIES-1:0] vld, sp, wr, match;
   logic [VPN_W-1:0]   tag [ENTRIES];
   logic [VPN_W-1:0]   ppn [ENTRIES];
   logic [VPN_W-1:0]   eff [ENTRIES];
   logic [IDX_W-1:0]   ptr;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      assign match[g] = vld[g] && (sp[g]
                        ? (tag[g][VPN_W-1:SP_BITS] == lk_vpn[VPN_W-1:SP_BITS])
                        : (tag[g] == lk_vpn));
      assign eff[g]   = sp[g] ? {ppn[g][VPN_W-1:SP_BITS], lk_vpn[SP_BITS-1:0]} : ppn[g];
   end

   always_comb begin
      hit     = |match;
      hit_ppn = '0;
      hit_wr  = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         hit_ppn = hit_ppn | (eff[i] & {VPN_W{match[i]}});
         hit_wr  = hit_wr  | (wr[i] & match[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld <= '0;
         sp  <= '0;
         wr  <= '0;
         ptr <= '0;
         for (int i = 0; i < ENTRIES; i++) begin
            tag[i] <= '0;
            ppn[i] <= '0;
         end
      end else if (clr) begin
         vld <= '0;
      end else if (fill_en) begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (ptr == IDX_W'(i)) begin
               vld[i] <= 1'b1;
               sp[i]  <= fill_sp;
               wr[i]  <= fill_wr;
               tag[i] <= lk_vpn;
               ppn[i] <= fill_ppn;
            end
         end
         ptr <= (ptr == IDX_W'(ENTRIES-1)) ? '0 : ptr + 1'b1;
      end
   end
endmodule

// File: rtl/pt_mmu_walk.sv
module pt_mmu_walk
   import pt_mmu_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int PAGE_BITS = 12,
   parameter int SP_BITS   = 8,
   localparam int VPN_W    = ADDR_W - PAGE_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   output logic              resp_valid,
   output logic [ADDR_W-1:0] resp_addr,
   output logic              resp_abort,
   output logic              pte_rd_req,
   output logic [ADDR_W-1:0] pte_rd_addr,
   input  logic              pte_rd_ack,
   input  logic [PTE_W-1:0]  pte_rd_data,
   input  logic              tlb_hit,
   input  logic [VPN_W-1:0]  tlb_ppn,
   input  logic              tlb_wr,
   output logic              fill_en,
   output logic [VPN_W-1:0]  fill_ppn,
   output logic              fill_sp,
   output logic              fill_wr,
   input  logic [VPN_W-1:0]  tbase,
   input  logic [VPN_W-1:0]  scr_ppn,
   input  logic              scr_en,
   input  logic              inv_chk,
   input  logic [FLT_N-1:0]  abt_en,
   input  logic              clr_busy,
   output logic [FLT_N-1:0]  flt_set,
   output logic              clr_ok
);
   walk_st_e                 st;
   logic [VPN_W-1:0]         vpn, dat_ppn, src_ppn;
   logic [PAGE_BITS-1:0]     off;
   logic [ADDR_W:0]          pte_sum;
   logic                     cap, src_v, src_w, accept, go_done, go_fetch, abort_d, abort_q;
   logic [FLT_N-1:0]         f;
   logic [ADDR_W-1:0]        phys_d;

   always_comb begin
      vpn     = req_addr[ADDR_W-1:PAGE_BITS];
      off     = req_addr[PAGE_BITS-1:0];
      pte_sum = {1'b0, tbase, {PAGE_BITS{1'b0}}} + (ADDR_W+1)'({vpn, 2'b00});
      cap     = pte_sum[ADDR_W];
      dat_ppn = pte_rd_data[PTE_SP_BIT]
                ? {pte_rd_data[VPN_W-1:SP_BITS], vpn[SP_BITS-1:0]}
                : pte_rd_data[VPN_W-1:0];
      if (st == ST_FETCH) begin
         src_ppn = dat_ppn;
         src_v   = pte_rd_data[PTE_V_BIT];
         src_w   = pte_rd_data[PTE_WR_BIT];
      end else begin
         src_ppn = cap ? '0 : tlb_ppn;
         src_v   = 1'b1;
         src_w   = tlb_wr;
      end
      f         = '0;
      f[FI_CAP] = cap;
      f[FI_INV] = !cap && !src_v && inv_chk;
      f[FI_WV]  = !cap && src_v && req_write && !src_w;
      phys_d    = (|f && scr_en) ? {scr_ppn, off} : {src_ppn, off};
      abort_d   = !scr_en && |(f & abt_en);
      accept    = (st == ST_IDLE) && req_valid && !clr_busy;
      go_done   = (accept && (cap || tlb_hit)) || (st == ST_FETCH && pte_rd_ack);
      go_fetch  = accept && !cap && !tlb_hit;
   end

   assign flt_set     = go_done ? f : '0;
   assign fill_en     = (st == ST_FETCH) && pte_rd_ack && pte_rd_data[PTE_V_BIT];
   assign fill_ppn    = pte_rd_data[VPN_W-1:0];
   assign fill_sp     = pte_rd_data[PTE_SP_BIT];
   assign fill_wr     = pte_rd_data[PTE_WR_BIT];
   assign pte_rd_req  = (st == ST_FETCH);
   assign pte_rd_addr = pte_sum[ADDR_W-1:0];
   assign clr_ok      = (st != ST_FETCH);
   assign resp_valid  = (st == ST_DONE);
   assign resp_abort  = resp_valid && abort_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         resp_addr <= '0;
         abort_q   <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE:  if (go_done) st <= ST_DONE; else if (go_fetch) st <= ST_FETCH;
            ST_FETCH: if (pte_rd_ack) st <= ST_DONE;
            default:  st <= ST_IDLE;
         endcase
         if (go_done) begin
            resp_addr <= phys_d;
            abort_q   <= abort_d;
         end
      end
   end
endmodule

// File: rtl/pt_mmu.sv
module pt_mmu
   import pt_mmu_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int PAGE_BITS   = 12,
   parameter int SP_BITS     = 8,
   parameter int TLB_ENTRIES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   output logic              resp_valid,
   output logic [ADDR_W-1:0] resp_addr,
   output logic              resp_abort,
   output logic              pte_rd_req,
   output logic [ADDR_W-1:0] pte_rd_addr,
   input  logic              pte_rd_ack,
   input  logic [PTE_W-1:0]  pte_rd_data,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] reg_rdata,
   output logic              irq
);
   localparam int VPN_W = ADDR_W - PAGE_BITS;

   if (VPN_W > PTE_V_BIT || VPN_W <= SP_BITS || TLB_ENTRIES < 2 || ADDR_W > PTE_W)
      $error("pt_mmu: parameter set does not fit the entry layout");

   logic              tlb_hit, tlb_wr, fill_en, fill_sp, fill_wr;
   logic              inv_chk, scr_en, clr_busy, clr_fire, clr_ok;
   logic [VPN_W-1:0]  tlb_ppn, fill_ppn, tbase, scr_ppn;
   logic [FLT_N-1:0]  abt_en, flt_set;

   pt_mmu_regs #(.ADDR_W(ADDR_W), .VPN_W(VPN_W)) regs_i (
      .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
      .clr_ok, .flt_set, .flt_va(req_addr), .inv_chk, .abt_en,
      .tbase, .scr_ppn, .scr_en, .clr_busy, .clr_fire, .irq);

   pt_mmu_tlb #(.VPN_W(VPN_W), .ENTRIES(TLB_ENTRIES), .SP_BITS(SP_BITS)) tlb_i (
      .clk, .rst_n, .lk_vpn(req_addr[ADDR_W-1:PAGE_BITS]), .hit(tlb_hit),
      .hit_ppn(tlb_ppn), .hit_wr(tlb_wr), .fill_en, .fill_ppn, .fill_sp,
      .fill_wr, .clr(clr_fire));

   pt_mmu_walk #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .SP_BITS(SP_BITS)) walk_i (
      .clk, .rst_n, .req_valid, .req_addr, .req_write, .resp_valid, .resp_addr,
      .resp_abort, .pte_rd_req, .pte_rd_addr, .pte_rd_ack, .pte_rd_data,
      .tlb_hit, .tlb_ppn, .tlb_wr, .fill_en, .fill_ppn, .fill_sp, .fill_wr,
      .tbase, .scr_ppn, .scr_en, .inv_chk, .abt_en, .clr_busy, .flt_set, .clr_ok);
endmodule

// File: rtl/pt_mmu_chk.sv
module pt_mmu_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              resp_valid,
   input logic              resp_abort,
   input logic              pte_rd_req,
   input logic              pte_rd_ack,
   input logic [ADDR_W-1:0] pte_rd_addr,
   input logic              reg_we,
   input logic [2:0]        reg_addr,
   input logic [ADDR_W-1:0] reg_wdata,
   input logic              clr_busy,
   input logic              scr_en
);
   logic clr_cmd;
   assign clr_cmd = reg_we && (reg_addr == 3'd0) && reg_wdata[8];

   // R2: an outstanding table read holds its request and address
   p_pte_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pte_rd_req && !pte_rd_ack |=> pte_rd_req && $stable(pte_rd_addr));

   // R11: completion lasts exactly one cycle
   p_resp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid);

   // R11: a table read never overlaps a completion
   p_resp_no_fetch_r11: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> !pte_rd_req);

   // R10: the clear command raises the busy flag on the next cycle
   p_busy_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clr_cmd |=> clr_busy);

   // R10: with no read in flight, busy drops after one cycle
   p_busy_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clr_busy && !pte_rd_req && !clr_cmd |=> !clr_busy);

   // R10: no new table read starts while clearing
   p_no_fetch_clearing_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clr_busy && !pte_rd_req |=> !pte_rd_req);

   // R8: with the redirect on, no completion aborts
   p_redirect_no_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && scr_en |-> !resp_abort);
endmodule

bind pt_mmu pt_mmu_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk, .rst_n, .resp_valid, .resp_abort, .pte_rd_req, .pte_rd_ack,
   .pte_rd_addr, .reg_we, .reg_addr, .reg_wdata, .clr_busy, .scr_en);

// File: tb/pt_mmu_tb_top.sv
`timescale 1ns/1ps
module pt_mmu_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [31:0] req_addr = '0;
   logic        resp_valid, resp_abort, pte_rd_req, irq;
   logic [31:0] resp_addr, pte_rd_addr, reg_rdata;
   logic        pte_rd_ack = 1'b0;
   logic [31:0] pte_rd_data = '0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;

   int n_cmp = 0, n_bad = 0, fetches = 0, wait_cnt = 0;
   logic [31:0] last_fetch = '0;
   logic [6:0]  ctl_m = '0;
   logic        scr_en_m = 1'b0;
   logic [19:0] scr_ppn_m = '0, base_m = '0;
   logic [2:0]  cause_m = '0;
   logic [31:0] fva_m = '0;

   always #4 clk = ~clk;

   pt_mmu dut_i (.*);

   function automatic logic [31:0] pte_for(input logic [19:0] vpn);
      logic [31:0] p;
      logic [3:0]  sel;
      p = '0;
      if (vpn[19:16] == 4'hA) begin
         p[31]   = 1'b1;
         p[19:0] = {vpn[19:8] ^ 12'h5A5, 8'h00};
         sel     = vpn[11:8];
      end else begin
         p[19:0] = vpn ^ 20'h5A5A5;
         sel     = vpn[3:0];
      end
      p[28] = (sel != 4'hF);
      p[29] = (sel != 4'hE);
      return p;
   endfunction

   function automatic void model(input logic [31:0] va, input logic wr,
                                 output logic [31:0] phys, output logic ab,
                                 output logic [2:0] f);
      logic [19:0] vpn, ppn;
      logic [32:0] sum;
      logic [31:0] p;
      vpn = va[31:12];
      sum = {1'b0, base_m, 12'h000} + 33'({vpn, 2'b00});
      p   = pte_for(vpn);
      ppn = p[31] ? {p[19:8], vpn[7:0]} : p[19:0];
      f   = '0;
      if (sum[32]) begin f[2] = 1'b1; ppn = '0; end
      else if (!p[28]) f[0] = ctl_m[0];
      else if (wr && !p[29]) f[1] = 1'b1;
      if (|f && scr_en_m) begin phys = {scr_ppn_m, va[11:0]}; ab = 1'b0; end
      else begin phys = {ppn, va[11:0]}; ab = |(f & {ctl_m[5], ctl_m[3], ctl_m[1]}); end
   endfunction

   // table memory: answers two cycles after the request
   always @(negedge clk) begin
      if (pte_rd_ack) begin
         pte_rd_ack = 1'b0;
         wait_cnt   = 0;
      end else if (pte_rd_req) begin
         wait_cnt++;
         if (wait_cnt == 2) begin
            last_fetch  = pte_rd_addr;
            pte_rd_data = pte_for(20'((pte_rd_addr - {base_m, 12'h000}) >> 2));
            pte_rd_ack  = 1'b1;
            fetches++;
         end
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
      if (a == 3'd0) ctl_m = d[6:0];
      if (a == 3'd1) base_m = d[19:0];
      if (a == 3'd2) begin scr_ppn_m = d[19:0]; scr_en_m = d[31]; end
      if (a == 3'd3) cause_m = cause_m & ~d[2:0];
   endtask

   task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic access(input logic [31:0] va, input logic wr,
                         output logic [31:0] pa, output logic ab);
      int n;
      @(negedge clk);
      req_valid = 1'b1; req_addr = va; req_write = wr;
      n = 0;
      do begin
         @(posedge clk); #1; n++;
      end while (!resp_valid && n < 100);
      pa = resp_addr; ab = resp_abort;
      req_valid = 1'b0;
   endtask

   // access plus model comparison; cause and fault-VA bookkeeping
   task automatic acc_chk(input string req, input logic [31:0] va, input logic wr);
      logic [31:0] pa, epa;
      logic ab, eab;
      logic [2:0] f;
      model(va, wr, epa, eab, f);
      access(va, wr, pa, ab);
      check({req, " addr"}, pa, epa);
      check({req, " abort"}, {31'd0, ab}, {31'd0, eab});
      cause_m = cause_m | f;
      if (|f) fva_m = va;
   endtask

   task automatic clear_tlb();
      logic [31:0] d;
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = {23'd0, 1'b1, 1'b0, ctl_m};
      @(negedge clk);
      reg_we = 1'b0;
      #1 check("R10 busy set", {31'd0, reg_rdata[9]}, 32'd1);
      do reg_rd(3'd0, d); while (d[9]);
      check("R10 busy cleared", {31'd0, d[9]}, 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] d, pa;
      logic ab;
      int f0;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state
      check("reset resp_valid", {31'd0, resp_valid}, 32'd0);
      check("reset irq", {31'd0, irq}, 32'd0);
      reg_rd(3'd0, d); check("reset ctrl", d, 32'd0);
      reg_rd(3'd3, d); check("reset cause", d, 32'd0);

      reg_wr(3'd1, 32'h0000_0100);
      // R1 / R2: first access misses and fetches base + VPN*4
      f0 = fetches;
      acc_chk("R1 translate", 32'h0000_3ABC, 1'b0);
      check("R2 fetch addr", last_fetch, 32'h0010_000C);
      check("R2 one fetch", fetches - f0, 1);
      // R3: hit, then round-robin eviction
      f0 = fetches;
      acc_chk("R3 hit", 32'h0000_3004, 1'b1);
      check("R3 hit no fetch", fetches - f0, 0);
      for (int i = 0; i < 8; i++) acc_chk("R3 fill", {20'h00010 + 20'(i), 12'h010}, 1'b0);
      f0 = fetches;
      acc_chk("R3 kept", 32'h0001_1555, 1'b0);
      check("R3 second entry kept", fetches - f0, 0);
      acc_chk("R3 evicted", 32'h0000_3000, 1'b0);
      check("R3 first entry evicted", fetches - f0, 1);
      // R10: clear then miss
      clear_tlb();
      f0 = fetches;
      acc_chk("R10 after clear", 32'h0001_1000, 1'b0);
      check("R10 refetch after clear", fetches - f0, 1);
      // R4: superpage
      acc_chk("R4 superpage", 32'hA123_4567, 1'b0);
      check("R4 superpage addr", resp_addr, 32'hFB73_4567);
      f0 = fetches;
      acc_chk("R4 same region", 32'hA12F_F001, 1'b1);
      check("R4 region hit no fetch", fetches - f0, 0);
      // R5 / R9: invalid entry
      reg_wr(3'd0, 32'h0000_0007);
      f0 = fetches;
      acc_chk("R5 invalid abort", 32'h0002_F123, 1'b0);
      acc_chk("R5 invalid again", 32'h0002_F124, 1'b0);
      check("R5 invalid not cached", fetches - f0, 2);
      reg_rd(3'd3, d); check("R9 cause inv", d, 32'd1);
      reg_rd(3'd4, d); check("R9 fault va", d, 32'h0002_F124);
      check("R9 irq", {31'd0, irq}, 32'd1);
      reg_wr(3'd3, 32'd1);
      reg_rd(3'd3, d); check("R9 w1c", d, 32'd0);
      check("R9 irq dropped", {31'd0, irq}, 32'd0);
      reg_wr(3'd0, 32'h0000_0001);
      acc_chk("R5 no abort", 32'h0002_F777, 1'b0);
      check("R9 irq disabled", {31'd0, irq}, 32'd0);
      reg_wr(3'd3, 32'd7);
      // R6: write violation
      reg_wr(3'd0, 32'h0000_0018);
      acc_chk("R6 write viol", 32'h0002_E010, 1'b1);
      reg_rd(3'd3, d); check("R6 cause wv", d, 32'd2);
      acc_chk("R6 read ok", 32'h0002_E020, 1'b0);
      reg_wr(3'd3, 32'd7);
      // R8: redirect
      reg_wr(3'd0, 32'h0000_0003);
      reg_wr(3'd2, 32'h8007_7777);
      acc_chk("R8 redirect", 32'h0003_F0AB, 1'b0);
      check("R8 scratch addr", resp_addr, 32'h7777_70AB);
      reg_rd(3'd3, d); check("R8 cause kept", d, 32'd1);
      reg_wr(3'd2, 32'h0000_0000);
      reg_wr(3'd3, 32'd7);
      // R7: overflow
      reg_wr(3'd0, 32'h0000_0060);
      reg_wr(3'd1, 32'h000F_FF00);
      f0 = fetches;
      acc_chk("R7 overflow", 32'h5000_0123, 1'b0);
      check("R7 no fetch", fetches - f0, 0);
      reg_rd(3'd3, d); check("R7 cause cap", d, 32'd4);
      reg_wr(3'd0, 32'h0000_0000);
      acc_chk("R7 page zero", 32'h5000_0456, 1'b0);
      reg_wr(3'd1, 32'h0000_0100);
      reg_wr(3'd3, 32'd7);
      clear_tlb();
      // random traffic
      for (int it = 0; it < 300; it++) begin
         logic [19:0] vpn;
         if (it % 25 == 0) begin
            reg_wr(3'd0, {25'd0, 7'($urandom)});
            reg_wr(3'd2, {($urandom % 4) == 0, 11'd0, 20'($urandom)});
         end
         case ($urandom % 3)
            0: vpn = 20'h00100 + 20'($urandom % 40);
            1: vpn = {4'hA, 4'($urandom), 4'($urandom % 4), 8'($urandom)};
            default: vpn = {16'h0002, 4'($urandom)};
         endcase
         acc_chk("R11 random", {vpn, 12'($urandom)}, 1'($urandom));
         reg_rd(3'd3, d); check("R9 random cause", d, {29'd0, cause_m});
         check("R9 random irq", {31'd0, irq},
               {31'd0, |(cause_m & {ctl_m[6], ctl_m[4], ctl_m[2]})});
         if (cause_m != 0) begin
            reg_rd(3'd4, d); check("R9 random fault va", d, fva_m);
         end
         if ($urandom % 4 == 0) reg_wr(3'd3, {29'd0, 3'($urandom)});
         if ($urandom % 40 == 0) clear_tlb();
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule